// File: doc/BRIEF.md
# Card-slot access strobe timing sequencer

This block times the read and write strobes of an expansion-card bus with two card slots. Each slot has three address spaces: I/O, attribute memory and common memory. A 32-bit configuration word holds a 5-bit count for every slot and space pair, plus one fast bit per slot. When an access is launched, the block takes the count for the target slot and space and builds an internal tick from it. The tick fires once every count+1 memory clocks (called N below). The block then walks through address setup, strobe assertion and strobe release, counting each phase in whole ticks. When the access is over it raises a one-cycle completion pulse.

A 16-bit access split into two 8-bit I/O halves runs two strobes under one address-valid window. The second strobe has its own setup gap of two ticks. A card wait line is synchronised through two flops. While it is high during a strobe, the strobe is held. The configuration word has no reset value and must be written before the first access. Every access copies its timing when it is launched.

The controller is a Moore machine with six named states:
- IDLE: waits for start.
- LAUNCH: one clock with the address valid.
- SETUP: 3 ticks, or 1 tick in fast mode.
- STROBE: 3 ticks, frozen while the synchronised wait is high.
- GAP: 2 ticks, before the second half of a split access.
- DONE: one clock with the completion pulse.

The transitions are:
- IDLE to LAUNCH on start.
- LAUNCH to SETUP always.
- SETUP to STROBE on the last setup tick.
- STROBE to GAP on the last tick of the first half of a split access.
- STROBE to DONE on the last tick otherwise.
- GAP to STROBE on the last gap tick.
- DONE to IDLE always.

Top module: `card_strobe_seq`

## Requirements
- R1: The configuration word is captured from `cfg_wdata` on a clock edge where `cfg_we` is high. For slot s, the field base is 16*s. Within a slot, the I/O count is at base+4:base, the attribute count at base+9:base+5, the common memory count at base+14:base+10 and the fast bit at base+15.
- R2: The count is chosen by `slot` and `space`: 0 selects I/O, 1 attribute, 2 common memory, and 3 is treated as common memory. One tick lasts N = count+1 memory clocks.
- R3: With the fast bit clear, `addr_valid` is high for 3N+1 clocks before the first strobe rises. `addr_valid` rises in the clock after the edge that samples `start`.
- R4: With the fast bit set, `addr_valid` is high for N+1 clocks before the first strobe.
- R5: Each strobe lasts 3N clocks whatever the fast bit. `wr_strobe` is used when `is_write` is 1 and `rd_strobe` when it is 0. The two strobes are never high together, and a strobe is only high while `addr_valid` is high.
- R6: With `split16` set, the first strobe is followed by 2N clocks with `addr_valid` high and no strobe, then by a second strobe of 3N clocks. With `split16` clear there is exactly one strobe.
- R7: `wait_req` passes through two flops. Each clock it is seen high during a strobe lengthens that strobe by one clock.
- R8: `done` is high for exactly one clock, in the clock after the last strobe falls. `addr_valid` and both strobes are low in that clock. The block is then idle.
- R9: `start` is ignored while an access is in progress.
- R10: A configuration write during an access changes only later accesses.
- R11: While `rst_n` is low and after reset, `addr_valid`, `rd_strobe`, `wr_strobe` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 32 | Configuration word to write |
| start | input | 1 | Launch an access (sampled only when idle) |
| slot | input | 1 | Target card slot |
| space | input | 2 | Address space: 0 I/O, 1 attribute, 2/3 common memory |
| is_write | input | 1 | 1 = write strobe, 0 = read strobe |
| split16 | input | 1 | Split access into two 8-bit halves |
| wait_req | input | 1 | Asynchronous card wait request, active high |
| addr_valid | output | 1 | Address and select lines are valid |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| done | output | 1 | One-clock completion pulse |

## Verification
A wrong state or phase count shows up as a wrong segment length in the `addr_valid`/strobe pattern. It is visible within one access, so at most about 13N clocks after `start`. A missing GAP state makes a split access show a single strobe. A stale latched count changes every segment of the next access, not only one. A wait hold that leaks outside STROBE, or a synchroniser of the wrong depth, changes the length of the stretched strobe by a whole number of clocks. The bench measures each segment in clocks and compares it with values computed from the configuration it wrote.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SETUP,
        ST_STROBE,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    localparam int PH_W = 2;
    localparam logic [PH_W-1:0] SETUP_TICKS_NORM = 2'd3;
    localparam logic [PH_W-1:0] SETUP_TICKS_FAST = 2'd1;
    localparam logic [PH_W-1:0] STROBE_TICKS     = 2'd3;
    localparam logic [PH_W-1:0] GAP_TICKS        = 2'd2;

    localparam logic [1:0] SPACE_IO   = 2'd0;
    localparam logic [1:0] SPACE_ATTR = 2'd1;
    localparam logic [1:0] SPACE_MEM  = 2'd2;
endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/cs_timing_sel.sv
module cs_timing_sel #(
    parameter int CNT_W  = 5,
    parameter int NSLOT  = 2,
    parameter int SLOT_W = 1,
    parameter int CFG_W  = NSLOT * (3 * CNT_W + 1)
) (
    input  logic [CFG_W-1:0]  cfg,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        space,
    output logic [CNT_W-1:0]  cnt,
    output logic              fast
);
    import cs_pkg::*;
    localparam int FIELD_W = 3 * CNT_W + 1;

    int base;
    int sel;

    always_comb begin
        base = int'(slot) * FIELD_W;
        unique case (space)
            SPACE_IO:   sel = 0;
            SPACE_ATTR: sel = 1;
            default:    sel = 2;
        endcase
        cnt  = cfg[base + sel * CNT_W +: CNT_W];
        fast = cfg[base + 3 * CNT_W];
    end
endmodule

// File: rtl/cs_tick_div.sv
module cs_tick_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] div_q;

    assign tick = !clear && !hold && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear) begin
            div_q <= '0;
        end else if (!hold) begin
            if (div_q == limit) div_q <= '0;
            else                div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq #(
    parameter int CNT_W  = 5,
    parameter int NSLOT  = 2,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    parameter int CFG_W  = NSLOT * (3 * CNT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        space,
    input  logic              is_write,
    input  logic              split16,
    input  logic              wait_req,
    output logic              addr_valid,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              done
);
    import cs_pkg::*;

    // configuration word: deliberately no reset, software programs it first
    logic [CFG_W-1:0] cfg_q;
    always_ff @(posedge clk) begin
        if (cfg_we) cfg_q <= cfg_wdata;
    end

    logic [CNT_W-1:0] sel_cnt;
    logic             sel_fast;

    cs_timing_sel #(.CNT_W(CNT_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W), .CFG_W(CFG_W)) u_sel (
        .cfg   (cfg_q),
        .slot  (slot),
        .space (space),
        .cnt   (sel_cnt),
        .fast  (sel_fast)
    );

    logic wait_s;
    cs_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wait_req),
        .sync_out (wait_s)
    );

    seq_state_t       state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             half_q, half_d;
    logic [CNT_W-1:0] cnt_q;
    logic             fast_q, wr_q, split_q;
    logic             tick, tick_clear, tick_hold, phase_end;

    assign tick_clear = (state_q == ST_IDLE) || (state_q == ST_LAUNCH) || (state_q == ST_DONE);
    assign tick_hold  = wait_s && (state_q == ST_STROBE);
    assign phase_end  = tick && (ph_q == 2'd1);

    cs_tick_div #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .hold  (tick_hold),
        .limit (cnt_q),
        .tick  (tick)
    );

    // next state
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        half_d  = half_q;
        if (tick && !phase_end) ph_d = ph_q - 2'd1;
        unique case (state_q)
            ST_IDLE: begin
                half_d = 1'b0;
                if (start) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_d = ST_SETUP;
                ph_d    = fast_q ? SETUP_TICKS_FAST : SETUP_TICKS_NORM;
            end
            ST_SETUP: begin
                if (phase_end) begin
                    state_d = ST_STROBE;
                    ph_d    = STROBE_TICKS;
                end
            end
            ST_STROBE: begin
                if (phase_end) begin
                    if (split_q && !half_q) begin
                        state_d = ST_GAP;
                        ph_d    = GAP_TICKS;
                        half_d  = 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_GAP: begin
                if (phase_end) begin
                    state_d = ST_STROBE;
                    ph_d    = STROBE_TICKS;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            half_q  <= 1'b0;
            cnt_q   <= '0;
            fast_q  <= 1'b0;
            wr_q    <= 1'b0;
            split_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            half_q  <= half_d;
            if (state_q == ST_IDLE && start) begin
                cnt_q   <= sel_cnt;
                fast_q  <= sel_fast;
                wr_q    <= is_write;
                split_q <= split16;
            end
        end
    end

    // outputs
    always_comb begin
        addr_valid = 1'b0;
        rd_strobe  = 1'b0;
        wr_strobe  = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_LAUNCH, ST_SETUP, ST_GAP: addr_valid = 1'b1;
            ST_STROBE: begin
                addr_valid = 1'b1;
                rd_strobe  = !wr_q;
                wr_strobe  = wr_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic addr_valid,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic done
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // R5
    strobe_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> addr_valid);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!addr_valid && !rd_strobe && !wr_strobe));

    // R8
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_strobe || wr_strobe));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !addr_valid && !done) |=> (addr_valid && !rd_strobe && !wr_strobe));

    // R4
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_strobe) || $rose(wr_strobe)) |-> $past(addr_valid));
endmodule

bind card_strobe_seq cs_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .addr_valid (addr_valid),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .done       (done)
);

// File: tb/tb_card_strobe_seq.sv
module tb_card_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [0:0]  slot = '0;
    logic [1:0]  space = '0;
    logic        is_write = 1'b0;
    logic        split16 = 1'b0;
    logic        wait_req = 1'b0;
    logic        addr_valid, rd_strobe, wr_strobe, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] cfgm = '0;

    card_strobe_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .start(start), .slot(slot), .space(space), .is_write(is_write),
        .split16(split16), .wait_req(wait_req), .addr_valid(addr_valid),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .done(done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int field_cnt(logic [31:0] c, int sl, int sp);
        int spi = (sp >= 2) ? 2 : sp;
        return int'(c[sl*16 + spi*5 +: 5]);
    endfunction

    function automatic bit field_fast(logic [31:0] c, int sl);
        return c[sl*16 + 15];
    endfunction

    function automatic int exp_setup(int n, bit f);
        return f ? (n + 1) : (3 * n + 1);
    endfunction

    // R1: configuration write
    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfgm = v;
    endtask

    task automatic run_access(input int sl, input int sp, input bit wr, input bit spl,
                              input int wlen, input bit mid_cfg, input bit busy_start);
        int n, su, ph, idx, s0, s1, s2, s3, badtype, donecnt;
        bit f;
        n = field_cnt(cfgm, sl, sp) + 1;
        f = field_fast(cfgm, sl);
        su = exp_setup(n, f);
        @(negedge clk);
        start = 1'b1; slot = 1'(sl); space = 2'(sp); is_write = wr; split16 = spl;
        @(negedge clk);
        start = 1'b0;
        ph = 0; s0 = 0; s1 = 0; s2 = 0; s3 = 0; badtype = 0; donecnt = 0;
        for (idx = 0; idx < 4000 && donecnt == 0; idx++) begin
            if (wlen > 0 && idx == su)        wait_req = 1'b1;
            if (wlen > 0 && idx == su + wlen) wait_req = 1'b0;
            if (mid_cfg && idx == 1) begin
                cfg_we = 1'b1; cfg_wdata = ~cfgm;
            end
            if (mid_cfg && idx == 2) begin
                cfg_we = 1'b0; cfgm = cfg_wdata;
            end
            if (busy_start && idx == 2) begin
                start = 1'b1; slot = ~slot; space = 2'd1; is_write = ~wr;
            end
            if (busy_start && idx == 3) start = 1'b0;
            if (done) begin
                donecnt = 1;
                // R8
                chk(!addr_valid && !rd_strobe && !wr_strobe, "R8 quiet at done",
                    int'(addr_valid), 0);
            end else begin
                if (rd_strobe || wr_strobe) begin
                    if ((wr && rd_strobe) || (!wr && wr_strobe)) badtype++;
                    if (ph == 0) ph = 1;
                    else if (ph == 2) ph = 3;
                end else if (addr_valid && ph == 1) begin
                    ph = 2;
                end
                case (ph)
                    0: s0++;
                    1: s1++;
                    2: s2++;
                    default: s3++;
                endcase
            end
            @(negedge clk);
        end
        // R3 / R4
        chk(s0 == su, f ? "R4 fast setup" : "R3 normal setup", s0, su);
        // R5 / R7
        chk(s1 == 3 * n + wlen, (wlen > 0) ? "R7 wait stretch" : "R5 strobe length", s1, 3 * n + wlen);
        chk(badtype == 0, "R5 strobe direction", badtype, 0);
        // R6
        chk(s2 == (spl ? 2 * n : 0), "R6 second setup", s2, spl ? 2 * n : 0);
        chk(s3 == (spl ? 3 * n : 0), "R6 second strobe", s3, spl ? 3 * n : 0);
        // R8
        chk(donecnt == 1, "R8 done seen", donecnt, 1);
        chk(!done && !addr_valid, "R8 single done then idle", int'(done), 0);
        if (busy_start) begin
            // R9
            int stray = 0;
            for (int k = 0; k < 4; k++) begin
                if (addr_valid || rd_strobe || wr_strobe || done) stray++;
                @(negedge clk);
            end
            chk(stray == 0, "R9 busy start ignored", stray, 0);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        // R11
        repeat (3) @(negedge clk);
        chk(!addr_valid && !rd_strobe && !wr_strobe && !done, "R11 in reset", int'(addr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!addr_valid && !rd_strobe && !wr_strobe && !done, "R11 after reset", int'(done), 0);

        // R1 R2: distinct counts per field, slot 0 normal, slot 1 fast
        write_cfg({1'b1, 5'd6, 5'd4, 5'd2, 1'b0, 5'd5, 5'd3, 5'd1});
        for (int sl = 0; sl < 2; sl++)
            for (int sp = 0; sp < 4; sp++)
                run_access(sl, sp, sp[0], 1'b0, 0, 1'b0, 1'b0);

        // R3 R4 minimum and maximum counts
        write_cfg({1'b1, 15'd0, 1'b0, 10'd0, 5'd31});
        run_access(0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run_access(1, 2, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        write_cfg({1'b1, 5'd31, 10'd0, 1'b0, 15'd0});
        run_access(0, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run_access(1, 2, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        // R6 split, fast and normal
        write_cfg({1'b1, 10'd0, 5'd2, 1'b0, 10'd0, 5'd1});
        run_access(0, 0, 1'b1, 1'b1, 0, 1'b0, 1'b0);
        run_access(1, 0, 1'b0, 1'b1, 0, 1'b0, 1'b0);

        // R7 wait stretch, short and long
        run_access(0, 0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
        run_access(1, 0, 1'b1, 1'b1, 7, 1'b0, 1'b0);

        // R10 config write mid access, then new timing applies
        write_cfg(32'h0000_0C63);
        run_access(0, 2, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        run_access(0, 2, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        // R9 start while busy
        run_access(1, 1, 1'b1, 1'b0, 0, 1'b0, 1'b1);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [31:0] v;
            v = $urandom;
            v[4:0] = v[4:0] & 5'h0F; v[20:16] = v[20:16] & 5'h0F;
            write_cfg(v);
            run_access(int'($urandom % 2), int'($urandom % 4), 1'($urandom),
                       1'($urandom), ($urandom % 3 == 0) ? int'($urandom % 6) + 1 : 0,
                       1'b0, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule